// File: doc/BRIEF.md
# Serial Bus Clock and Launch Timer

This block generates the clock for a two-wire serial bus and times the data wire against it. A parent clock is divided by a programmable count: each level of the bus clock lasts the divider value plus one parent cycle. The bus clock rests high while no transfer is running. After every falling bus-clock edge, the block waits a programmable number of parent cycles. It then launches the next outgoing data bit and pulses a shift strobe back to the framing sequencer. On every rising edge it samples the data pin, after synchronising it, and pulses a sample strobe.

A line-control word can take direct control of either wire, each with its own enable. The block also returns the synchronised levels of both pins so that software can read the real bus state. The clock-control word carries the divider in its low byte and the launch delay in the three bits above it. A delay of zero behaves as one, so the data wire never moves on the same parent edge as a falling clock. A sequencer built for a 3 MHz default bus targets at most 20 MHz. It picks the divider and sets the delay to roughly half the divide value.

Top module: `serclk_gen`

## Requirements
- R1: With `run_i` high, each high and each low phase of `scl_o` lasts `clk_ctrl_i[7:0]` + 1 parent cycles, so one bus period is 2 × (divider + 1) parent cycles.
- R2: After reset, and while `run_i` is low, `scl_o` and `sda_o` are high and neither strobe pulses.
- R3: A delay d = `clk_ctrl_i[10:8]` in the range 1..7 makes `sda_o` take the current `tx_bit_i` d parent cycles after `scl_o` falls. `shift_stb_o` pulses for one cycle in that same cycle.
- R4: A delay field of 0 acts as a delay of 1, and `sda_o` never changes on the edge where `scl_o` falls.
- R5: `sample_stb_o` pulses for exactly the first parent cycle of each high `scl_o` phase. `rx_bit_o` then holds the synchronised `sda_i` level captured at that rising edge.
- R6: `line_ctrl_i[0]` = 1 forces `sda_o` to `line_ctrl_i[1]` and `sda_oe_o` to 1, whatever the sequencer drives.
- R7: `line_ctrl_i[2]` = 1 forces `scl_o` to `line_ctrl_i[3]`, even while the divider is running.
- R8: `line_rd_o` is {SCL pin, SDA pin, `line_ctrl_i[3:0]`}, with the SCL pin in bit 5 and the SDA pin in bit 4. The pin bits pass a two-stage synchroniser and reflect a pin change within three parent cycles.
- R9: Without the SDA override, `sda_oe_o` follows `tx_drive_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_ctrl_i | input | 11 | Bits 7:0 divider, bits 10:8 launch delay |
| line_ctrl_i | input | 4 | SDA override enable/value (bits 0/1), SCL override enable/value (bits 2/3) |
| run_i | input | 1 | Sequencer requests a running bus clock |
| tx_bit_i | input | 1 | Next outgoing data bit from the sequencer |
| tx_drive_i | input | 1 | Sequencer drives SDA (0 releases it) |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_o | output | 1 | Bus clock to the pin |
| sda_o | output | 1 | Data value to the pin |
| sda_oe_o | output | 1 | Data pin output enable |
| shift_stb_o | output | 1 | One-cycle pulse when a new bit has launched |
| sample_stb_o | output | 1 | One-cycle pulse after a rising bus-clock edge |
| rx_bit_o | output | 1 | Data bit sampled at the last rising edge |
| line_rd_o | output | 6 | Synchronised pin levels and override bits |

## Verification
The assertions take it as given that the clock-control word stays constant while `run_i` is high. They also take it as given that the launch delay is shorter than two bus-clock phases, so a launch can never line up with the next falling edge. The stimulus changes the divider, the delay and the sampled pin level only while the bus clock is stopped, and waits several cycles before it starts the clock again. It uses only delay/divider pairs with that margin, from a divider of 0 up to 7, and holds the overrides off during the timed runs.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
  localparam int DIV_W    = 8;
  localparam int DLY_W    = 3;
  localparam int SYNC_N   = 2;
  localparam int LC_W     = 4;
  localparam int LC_SDA_EN  = 0;
  localparam int LC_SDA_VAL = 1;
  localparam int LC_SCL_EN  = 2;
  localparam int LC_SCL_VAL = 3;
  localparam int RD_W     = LC_W + 2;
  localparam logic PIN_IDLE = 1'b1;
endpackage

// File: rtl/serclk_div.sv
module serclk_div #(
  parameter int DIV_W = serclk_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             scl_o,
  output logic             fall_nxt_o,
  output logic             rise_nxt_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             scl_q;
  logic             at_lim;

  // >= keeps a shrinking divider from wrapping the counter
  assign at_lim     = run_i && (cnt_q >= div_i);
  assign fall_nxt_o = at_lim && scl_q;
  assign rise_nxt_o = at_lim && !scl_q;
  assign scl_o      = scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      scl_q <= serclk_pkg::PIN_IDLE;
    end else if (!run_i) begin
      cnt_q <= '0;
      scl_q <= serclk_pkg::PIN_IDLE;
    end else if (at_lim) begin
      cnt_q <= '0;
      scl_q <= ~scl_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_toggle_at_limit_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((scl_q != $past(scl_q)) && $past(run_i)) |-> $past(cnt_q >= div_i));

  p_idle_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> scl_q);
endmodule

// File: rtl/serclk_launch.sv
module serclk_launch #(
  parameter int DLY_W = serclk_pkg::DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             fall_nxt_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             tx_bit_i,
  output logic             sda_o,
  output logic             shift_o
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] dly_eff;
  logic [DLY_W-1:0] dcnt_q;
  logic             sda_q;
  logic             shift_q;
  logic             launch;

  // zero would launch on the falling edge itself
  assign dly_eff = (dly_i == '0) ? ONE : dly_i;
  assign launch  = (dcnt_q == ONE);
  assign sda_o   = sda_q;
  assign shift_o = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcnt_q  <= '0;
      sda_q   <= serclk_pkg::PIN_IDLE;
      shift_q <= 1'b0;
    end else if (!run_i) begin
      dcnt_q  <= '0;
      sda_q   <= serclk_pkg::PIN_IDLE;
      shift_q <= 1'b0;
    end else begin
      shift_q <= launch;
      if (launch) sda_q <= tx_bit_i;
      if (fall_nxt_i)          dcnt_q <= dly_eff;
      else if (dcnt_q != '0)   dcnt_q <= dcnt_q - 1'b1;
    end
  end

  p_shift_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_q |=> !shift_q);

  p_no_launch_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_nxt_i |=> !shift_q);
endmodule

// File: rtl/serclk_line.sv
module serclk_line #(
  parameter int SYNC_N = serclk_pkg::SYNC_N,
  parameter int LC_W   = serclk_pkg::LC_W,
  localparam int RD_W  = LC_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [LC_W-1:0] line_ctrl_i,
  input  logic            scl_int_i,
  input  logic            sda_int_i,
  input  logic            sda_drv_i,
  input  logic            scl_pin_i,
  input  logic            sda_pin_i,
  output logic            scl_o,
  output logic            sda_o,
  output logic            sda_oe_o,
  output logic            sda_sync_o,
  output logic [RD_W-1:0] line_rd_o
);
  import serclk_pkg::*;

  // bit 1 = SCL, bit 0 = SDA through every stage
  for (genvar s = 0; s < SYNC_N; s++) begin : g_sync
    logic [1:0] q;
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= {2{PIN_IDLE}};
        else         q <= {scl_pin_i, sda_pin_i};
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= {2{PIN_IDLE}};
        else         q <= g_sync[s-1].q;
      end
    end
  end

  logic [1:0] pins_s;
  assign pins_s     = g_sync[SYNC_N-1].q;
  assign sda_sync_o = pins_s[0];

  assign scl_o    = line_ctrl_i[LC_SCL_EN] ? line_ctrl_i[LC_SCL_VAL] : scl_int_i;
  assign sda_o    = line_ctrl_i[LC_SDA_EN] ? line_ctrl_i[LC_SDA_VAL] : sda_int_i;
  assign sda_oe_o = line_ctrl_i[LC_SDA_EN] | sda_drv_i;
  assign line_rd_o = {pins_s[1], pins_s[0], line_ctrl_i};
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen #(
  parameter int DIV_W  = serclk_pkg::DIV_W,
  parameter int DLY_W  = serclk_pkg::DLY_W,
  parameter int SYNC_N = serclk_pkg::SYNC_N,
  localparam int CFG_W = DIV_W + DLY_W,
  localparam int LC_W  = serclk_pkg::LC_W,
  localparam int RD_W  = LC_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] clk_ctrl_i,
  input  logic [LC_W-1:0]  line_ctrl_i,
  input  logic             run_i,
  input  logic             tx_bit_i,
  input  logic             tx_drive_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             sda_oe_o,
  output logic             shift_stb_o,
  output logic             sample_stb_o,
  output logic             rx_bit_o,
  output logic [RD_W-1:0]  line_rd_o
);
  logic [DIV_W-1:0] div;
  logic [DLY_W-1:0] dly;
  logic scl_int, sda_int, fall_nxt, rise_nxt, sda_sync;
  logic sample_q, rx_q;

  assign div = clk_ctrl_i[DIV_W-1:0];
  assign dly = clk_ctrl_i[CFG_W-1:DIV_W];

  serclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i,
    .div_i      (div),
    .scl_o      (scl_int),
    .fall_nxt_o (fall_nxt),
    .rise_nxt_o (rise_nxt)
  );

  serclk_launch #(.DLY_W(DLY_W)) u_launch (
    .clk_i, .rst_ni, .run_i,
    .fall_nxt_i (fall_nxt),
    .dly_i      (dly),
    .tx_bit_i,
    .sda_o      (sda_int),
    .shift_o    (shift_stb_o)
  );

  serclk_line #(.SYNC_N(SYNC_N), .LC_W(LC_W)) u_line (
    .clk_i, .rst_ni, .line_ctrl_i,
    .scl_int_i  (scl_int),
    .sda_int_i  (sda_int),
    .sda_drv_i  (tx_drive_i),
    .scl_pin_i  (scl_i),
    .sda_pin_i  (sda_i),
    .scl_o, .sda_o, .sda_oe_o,
    .sda_sync_o (sda_sync),
    .line_rd_o
  );

  // capture on the rising bus-clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_q <= 1'b0;
      rx_q     <= 1'b0;
    end else begin
      sample_q <= rise_nxt;
      if (rise_nxt) rx_q <= sda_sync;
    end
  end

  assign sample_stb_o = sample_q;
  assign rx_bit_o     = rx_q;

  p_sample_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_q |-> (scl_int && !$past(scl_int)));

  p_sda_still_on_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scl_int) |-> $stable(sda_int));
endmodule

// File: tb/serclk_gen_tb_top.sv
module serclk_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [10:0] clk_ctrl_i = '0;
  logic [3:0]  line_ctrl_i = '0;
  logic        run_i = 1'b0;
  logic        tx_bit_i = 1'b0;
  logic        tx_drive_i = 1'b0;
  logic        scl_i = 1'b1;
  logic        sda_i = 1'b1;
  logic        scl_o, sda_o, sda_oe_o, shift_stb_o, sample_stb_o, rx_bit_o;
  logic [5:0]  line_rd_o;

  serclk_gen dut_i (.*);

  always #2 clk_i = ~clk_i;

  typedef struct { int half; int dly; bit rx; bit zdly; } exp_t;
  exp_t exp_q[$];

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // monitor state
  bit mon_act = 0, first_chg = 0, prev_scl = 1;
  int plen = 0, age = -1, tx_cnt = 0;

  always @(negedge clk_i) begin
    if (rst_ni && run_i && exp_q.size() > 0) begin
      exp_t e;
      bit chg;
      e = exp_q[0];
      if (!mon_act) begin
        mon_act = 1; first_chg = 1; plen = 0; age = -1; prev_scl = scl_o;
      end else begin
        chg = (scl_o != prev_scl);
        plen++;
        if (age >= 0) age++;
        if (chg) begin
          if (!first_chg) chk(plen == e.half, "R1 phase length", plen, e.half);
          first_chg = 0;
          plen = 0;
          if (!scl_o) age = 0;
        end
        prev_scl = scl_o;
        if (shift_stb_o) begin
          if (e.zdly) chk(age == e.dly, "R4 zero delay acts as one", age, e.dly);
          else        chk(age == e.dly, "R3 launch delay", age, e.dly);
          chk(sda_o == tx_bit_i, "R3 launched bit", sda_o, tx_bit_i);
          chk(!(chg && !scl_o), "R4 no launch on fall", chg, 0);
          age = -1;
          tx_cnt++;
          tx_bit_i <= tx_cnt[0] ^ tx_cnt[2];
        end
        if (sample_stb_o) begin
          chk(scl_o && chg, "R5 strobe on first high cycle", {scl_o, chg}, 3);
          chk(rx_bit_o == e.rx, "R5 sampled bit", rx_bit_o, e.rx);
        end
      end
    end else begin
      mon_act = 0;
    end
  end

  task automatic run_case(input int div, input int dly, input bit rx, input int ncyc);
    exp_t e;
    clk_ctrl_i = {dly[2:0], div[7:0]};
    sda_i = rx;
    step(4);
    e.half = div + 1; e.dly = (dly == 0) ? 1 : dly; e.rx = rx; e.zdly = (dly == 0);
    exp_q.push_back(e);
    run_i = 1'b1;
    step(ncyc);
    run_i = 1'b0;
    void'(exp_q.pop_front());
    step(2);
    @(negedge clk_i);
    chk(scl_o == 1'b1, "R2 idle scl", scl_o, 1);
    chk(sda_o == 1'b1, "R2 idle sda", sda_o, 1);
    chk(!shift_stb_o && !sample_stb_o, "R2 idle strobes", {shift_stb_o, sample_stb_o}, 0);
    step(1);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(2);
    @(negedge clk_i);
    chk(scl_o == 1 && sda_o == 1, "R2 reset lines", {scl_o, sda_o}, 3);
    chk(sda_oe_o == 0, "R9 reset oe", sda_oe_o, 0);
    chk(line_rd_o == 6'b110000, "R8 reset readback", line_rd_o, 6'b110000);
    step(1);

    run_case(0, 0, 1'b1, 40);
    run_case(1, 1, 1'b0, 60);
    run_case(3, 2, 1'b1, 80);
    run_case(5, 0, 1'b0, 100);
    run_case(7, 4, 1'b1, 120);
    run_case(2, 3, 1'b0, 60);

    // R7 SCL override while running
    clk_ctrl_i = {3'd1, 8'd1};
    run_i = 1'b1;
    line_ctrl_i = 4'b0100;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk(scl_o == 0, "R7 scl forced low", scl_o, 0);
    end
    line_ctrl_i = 4'b1100;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      chk(scl_o == 1, "R7 scl forced high", scl_o, 1);
    end
    run_i = 1'b0;
    line_ctrl_i = 4'b0000;
    step(2);

    // R6 SDA override
    tx_drive_i = 1'b0;
    line_ctrl_i = 4'b0001;
    @(negedge clk_i);
    chk(sda_o == 0 && sda_oe_o == 1, "R6 sda forced low", {sda_o, sda_oe_o}, 1);
    step(1);
    line_ctrl_i = 4'b0011;
    @(negedge clk_i);
    chk(sda_o == 1 && sda_oe_o == 1, "R6 sda forced high", {sda_o, sda_oe_o}, 3);
    step(1);

    // R9 drive enable follows sequencer
    line_ctrl_i = 4'b0000;
    tx_drive_i = 1'b1;
    @(negedge clk_i);
    chk(sda_oe_o == 1, "R9 oe on", sda_oe_o, 1);
    step(1);
    tx_drive_i = 1'b0;
    @(negedge clk_i);
    chk(sda_oe_o == 0, "R9 oe off", sda_oe_o, 0);
    step(1);

    // R8 readback of pins and override bits
    scl_i = 1'b0; sda_i = 1'b1; line_ctrl_i = 4'b1010;
    step(3);
    @(negedge clk_i);
    chk(line_rd_o == 6'b011010, "R8 readback A", line_rd_o, 6'b011010);
    step(1);
    scl_i = 1'b1; sda_i = 1'b0; line_ctrl_i = 4'b0101;
    step(3);
    @(negedge clk_i);
    chk(line_rd_o == 6'b100101, "R8 readback B", line_rd_o, 6'b100101);
    line_ctrl_i = 4'b0000;
    step(2);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule